// File: doc/BRIEF.md
# Per-Channel DMA Context Identifier Bank

This block holds one 32-bit context identifier for each implemented DMA channel. The upper 24 bits carry the process number and the lower 8 bits carry the address-space identifier (ASID). Together they identify the process that owns the channel. Software reads and writes these registers through a coprocessor-style access port. The access carries two opcode fields and two register-number fields, and a separate channel-number input picks which channel's register the access targets. That channel-number register is written beforehand and lives outside this block.

Only privileged code may touch the bank. A user-mode access that matches the decode raises a one-cycle undefined-instruction trap and changes nothing. A write is dropped while the targeted channel is running or queued. The channel state machine reports that condition as one busy bit per channel.

The block also drives a registered 8-bit ASID toward the memory-side bus, for address translation. This value is the low byte of the register belonging to the channel named on the active-channel input.

Top module: `dma_ctxid_bank`

## Requirements
- R1: Every channel register resets to zero, and after reset a privileged read of any channel returns 0.
- R2: An access is decoded only when `acc_op1`=0, `acc_crn`=11, `acc_crm`=15 and `acc_op2`=0. A privileged decoded write loads `acc_wdata` into the register of the channel given by `chan_sel`. A privileged decoded read returns that register on `rd_data` in the cycle after the request, with `acc_ack` high for that one cycle.
- R3: Each channel's register is independent: a write to one channel leaves the other channels' contents unchanged.
- R4: A decoded access with `acc_priv`=0 pulses `undef_trap` for one cycle, one cycle after the request. It gives no `acc_ack` and no read data, and it leaves every register unchanged.
- R5: A privileged decoded write whose selected channel has its `chan_busy` bit set is acknowledged but has no effect. Reads are still served while a channel is busy.
- R6: A request with any decode field different from R2 produces neither `acc_ack` nor `undef_trap` and changes nothing, whatever the privilege.
- R7: A `chan_sel` value at or above the channel count reads as 0 and ignores writes. It does not alias onto an implemented channel.
- R8: One cycle after the inputs, `asid_out` carries bits [7:0] of the register of channel `act_chan` while `act_valid` is 1. It is 0 when `act_valid` is 0 or `act_chan` is out of range. A register write therefore reaches `asid_out` one cycle after the write's clock edge.
- R9: `acc_ack` and `undef_trap` are never high together, and `rd_data` is 0 in every cycle that does not return a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_req | input | 1 | Access request, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_priv | input | 1 | 1 = privileged mode, 0 = user mode |
| acc_op1 | input | 3 | First opcode field of the access |
| acc_crn | input | 4 | Primary register number |
| acc_crm | input | 4 | Secondary register number |
| acc_op2 | input | 3 | Second opcode field of the access |
| acc_wdata | input | 32 | Write data |
| chan_sel | input | SEL_W | Channel targeted by the access |
| chan_busy | input | NUM_CH | Per-channel running-or-queued flag |
| act_valid | input | 1 | A channel is currently transferring |
| act_chan | input | SEL_W | Number of the transferring channel |
| acc_ack | output | 1 | Privileged decoded access completed |
| rd_data | output | 32 | Read data, valid when a read is acknowledged |
| undef_trap | output | 1 | Undefined-instruction pulse for user access |
| asid_out | output | 8 | ASID of the active channel toward the memory bus |

## Verification
The bench builds the block with two channels and a 4-bit channel selector. With these values the selector spans 16 codes but only two of them are implemented. Selector values 2 to 15 are therefore reachable, so out-of-range reads and writes can be exercised, including code 5, which would alias onto channel 1 if the index were simply truncated. Two busy bits let the bench hold one channel busy while writing the other, which shows that the write drop follows the selected channel rather than any busy channel.

// File: rtl/dma_ctxid_bank.sv
module dma_ctxid_bank #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_req,
  input  logic              acc_wr,
  input  logic              acc_priv,
  input  logic [2:0]        acc_op1,
  input  logic [3:0]        acc_crn,
  input  logic [3:0]        acc_crm,
  input  logic [2:0]        acc_op2,
  input  logic [31:0]       acc_wdata,
  input  logic [SEL_W-1:0]  chan_sel,
  input  logic [NUM_CH-1:0] chan_busy,
  input  logic              act_valid,
  input  logic [SEL_W-1:0]  act_chan,
  output logic              acc_ack,
  output logic [31:0]       rd_data,
  output logic              undef_trap,
  output logic [7:0]        asid_out
);

  localparam logic [2:0] DEC_OP1 = 3'd0;
  localparam logic [3:0] DEC_CRN = 4'd11;
  localparam logic [3:0] DEC_CRM = 4'd15;
  localparam logic [2:0] DEC_OP2 = 3'd0;

  logic [31:0] ctx [NUM_CH];
  logic        hit, sel_ok, sel_busy, wr_en;
  logic [31:0] sel_val;
  logic [7:0]  act_asid;

  assign hit = acc_req && acc_op1 == DEC_OP1 && acc_crn == DEC_CRN &&
               acc_crm == DEC_CRM && acc_op2 == DEC_OP2;

  always_comb begin
    sel_ok   = 1'b0;
    sel_busy = 1'b0;
    sel_val  = '0;
    act_asid = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (chan_sel == SEL_W'(i)) begin
        sel_ok   = 1'b1;
        sel_busy = chan_busy[i];
        sel_val  = ctx[i];
      end
      if (act_valid && act_chan == SEL_W'(i))
        act_asid = ctx[i][7:0];
    end
  end

  assign wr_en = hit && acc_priv && acc_wr && sel_ok && !sel_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) ctx[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++)
        if (wr_en && chan_sel == SEL_W'(i)) ctx[i] <= acc_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_ack    <= 1'b0;
      undef_trap <= 1'b0;
      rd_data    <= '0;
      asid_out   <= '0;
    end else begin
      acc_ack    <= hit && acc_priv;
      undef_trap <= hit && !acc_priv;
      rd_data    <= (hit && acc_priv && !acc_wr) ? sel_val : '0;
      asid_out   <= act_asid;
    end
  end

endmodule

// File: rtl/dma_ctxid_bank_chk.sv
module dma_ctxid_bank_chk #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned SEL_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_req,
  input logic              acc_wr,
  input logic              acc_priv,
  input logic [2:0]        acc_op1,
  input logic [3:0]        acc_crn,
  input logic [3:0]        acc_crm,
  input logic [2:0]        acc_op2,
  input logic [SEL_W-1:0]  chan_sel,
  input logic              act_valid,
  input logic              acc_ack,
  input logic [31:0]       rd_data,
  input logic              undef_trap,
  input logic [7:0]        asid_out
);

  logic dec_ok;
  assign dec_ok = acc_op1 == 3'd0 && acc_crn == 4'd11 && acc_crm == 4'd15 && acc_op2 == 3'd0;

  assert_ack_trap_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_ack && undef_trap));

  assert_idle_rd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_ack |-> rd_data == 32'd0);

  assert_user_traps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && dec_ok && !acc_priv) |=> (undef_trap && !acc_ack));

  assert_mismatch_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !dec_ok) |=> (!acc_ack && !undef_trap));

  assert_oor_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && dec_ok && acc_priv && !acc_wr &&
     ({{(32-SEL_W){1'b0}}, chan_sel} >= NUM_CH)) |=> (acc_ack && rd_data == 32'd0));

  assert_asid_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !act_valid |=> asid_out == 8'd0);

endmodule

bind dma_ctxid_bank dma_ctxid_bank_chk #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/dma_ctxid_bank_bench.sv
module dma_ctxid_bank_bench;

  typedef struct packed {
    logic        wr;
    logic        priv;
    logic [3:0]  sel;
    logic [1:0]  busy;
    logic [31:0] wd;
    logic        ack;
    logic        undef;
    logic [31:0] rd;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 4'd0, 2'b00, 32'h0,         1'b1, 1'b0, 32'h0},          // R1 reset value ch0
    '{1'b1, 1'b1, 4'd0, 2'b00, 32'hA5A5_1234, 1'b1, 1'b0, 32'h0},          // R2 write ch0
    '{1'b0, 1'b1, 4'd0, 2'b00, 32'h0,         1'b1, 1'b0, 32'hA5A5_1234},  // R2 read ch0
    '{1'b1, 1'b1, 4'd1, 2'b00, 32'h0000_BEEF, 1'b1, 1'b0, 32'h0},          // R3 write ch1
    '{1'b0, 1'b1, 4'd1, 2'b00, 32'h0,         1'b1, 1'b0, 32'h0000_BEEF},  // R3
    '{1'b0, 1'b1, 4'd0, 2'b00, 32'h0,         1'b1, 1'b0, 32'hA5A5_1234},  // R3 ch0 kept
    '{1'b1, 1'b0, 4'd0, 2'b00, 32'hFFFF_FFFF, 1'b0, 1'b1, 32'h0},          // R4 user write
    '{1'b0, 1'b0, 4'd0, 2'b00, 32'h0,         1'b0, 1'b1, 32'h0},          // R4 user read
    '{1'b0, 1'b1, 4'd0, 2'b00, 32'h0,         1'b1, 1'b0, 32'hA5A5_1234},  // R4 unchanged
    '{1'b1, 1'b1, 4'd0, 2'b01, 32'h1111_1111, 1'b1, 1'b0, 32'h0},          // R5 busy write
    '{1'b0, 1'b1, 4'd0, 2'b01, 32'h0,         1'b1, 1'b0, 32'hA5A5_1234},  // R5 read busy
    '{1'b1, 1'b1, 4'd1, 2'b01, 32'h2222_2222, 1'b1, 1'b0, 32'h0},          // R5 other busy
    '{1'b0, 1'b1, 4'd1, 2'b00, 32'h0,         1'b1, 1'b0, 32'h2222_2222},  // R5
    '{1'b1, 1'b1, 4'd1, 2'b10, 32'h3333_3333, 1'b1, 1'b0, 32'h0},          // R5 ch1 busy
    '{1'b0, 1'b1, 4'd1, 2'b00, 32'h0,         1'b1, 1'b0, 32'h2222_2222},  // R5
    '{1'b1, 1'b1, 4'd5, 2'b00, 32'h4444_4444, 1'b1, 1'b0, 32'h0},          // R7 oor write
    '{1'b0, 1'b1, 4'd5, 2'b00, 32'h0,         1'b1, 1'b0, 32'h0},          // R7 oor read
    '{1'b0, 1'b1, 4'd1, 2'b00, 32'h0,         1'b1, 1'b0, 32'h2222_2222},  // R7 no alias
    '{1'b0, 1'b1, 4'd15, 2'b00, 32'h0,        1'b1, 1'b0, 32'h0}           // R7 top code
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_req = 1'b0, acc_wr = 1'b0, acc_priv = 1'b0;
  logic [2:0]  acc_op1 = 3'd0, acc_op2 = 3'd0;
  logic [3:0]  acc_crn = 4'd11, acc_crm = 4'd15;
  logic [31:0] acc_wdata = '0;
  logic [3:0]  chan_sel = '0, act_chan = '0;
  logic [1:0]  chan_busy = '0;
  logic        act_valid = 1'b0;
  logic        acc_ack, undef_trap;
  logic [31:0] rd_data;
  logic [7:0]  asid_out;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  dma_ctxid_bank #(.NUM_CH(2), .SEL_W(4)) u_dma_ctxid_bank (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_wr(acc_wr), .acc_priv(acc_priv),
    .acc_op1(acc_op1), .acc_crn(acc_crn), .acc_crm(acc_crm), .acc_op2(acc_op2),
    .acc_wdata(acc_wdata), .chan_sel(chan_sel), .chan_busy(chan_busy),
    .act_valid(act_valid), .act_chan(act_chan), .acc_ack(acc_ack), .rd_data(rd_data),
    .undef_trap(undef_trap), .asid_out(asid_out));

  task automatic check(input string req, input logic [39:0] got, input logic [39:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drives one request cycle; returns at the negedge after the capturing edge
  task automatic access(input logic wr, input logic priv, input logic [3:0] sel,
                        input logic [1:0] busy, input logic [31:0] wd,
                        input logic [2:0] op1, input logic [3:0] crn,
                        input logic [3:0] crm, input logic [2:0] op2);
    @(negedge clk);
    acc_req = 1'b1; acc_wr = wr; acc_priv = priv; chan_sel = sel; chan_busy = busy;
    acc_wdata = wd; acc_op1 = op1; acc_crn = crn; acc_crm = crm; acc_op2 = op2;
    @(negedge clk);
    acc_req = 1'b0; chan_busy = 2'b00;
    acc_op1 = 3'd0; acc_crn = 4'd11; acc_crm = 4'd15; acc_op2 = 3'd0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {6'd0, acc_ack, undef_trap, rd_data}, 40'd0);
    check("R1 reset asid", {32'd0, asid_out}, 40'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].wr, VEC[i].priv, VEC[i].sel, VEC[i].busy, VEC[i].wd, 3'd0, 4'd11, 4'd15, 3'd0);
      check($sformatf("vector %0d", i), {6'd0, acc_ack, undef_trap, rd_data},
            {6'd0, VEC[i].ack, VEC[i].undef, VEC[i].rd});
    end

    // R6 each field off by one, privileged write then user read
    access(1'b1, 1'b1, 4'd0, 2'b00, 32'h9999_9999, 3'd1, 4'd11, 4'd15, 3'd0);
    check("R6 op1 mismatch", {6'd0, acc_ack, undef_trap, rd_data}, 40'd0);
    access(1'b1, 1'b1, 4'd0, 2'b00, 32'h9999_9999, 3'd0, 4'd10, 4'd15, 3'd0);
    check("R6 crn mismatch", {6'd0, acc_ack, undef_trap, rd_data}, 40'd0);
    access(1'b1, 1'b1, 4'd0, 2'b00, 32'h9999_9999, 3'd0, 4'd11, 4'd14, 3'd0);
    check("R6 crm mismatch", {6'd0, acc_ack, undef_trap, rd_data}, 40'd0);
    access(1'b0, 1'b0, 4'd0, 2'b00, 32'h0, 3'd0, 4'd11, 4'd15, 3'd1);
    check("R6 op2 mismatch user", {6'd0, acc_ack, undef_trap, rd_data}, 40'd0);
    access(1'b0, 1'b1, 4'd0, 2'b00, 32'h0, 3'd0, 4'd11, 4'd15, 3'd0);
    check("R6 ch0 unchanged", {6'd0, acc_ack, undef_trap, rd_data}, {6'd0, 2'b10, 32'hA5A5_1234});

    // R8 ASID output
    @(negedge clk); act_valid = 1'b1; act_chan = 4'd0;
    @(negedge clk);
    check("R8 asid ch0", {32'd0, asid_out}, {32'd0, 8'h34});
    act_chan = 4'd1;
    @(negedge clk);
    check("R8 asid ch1", {32'd0, asid_out}, {32'd0, 8'h22});
    access(1'b1, 1'b1, 4'd1, 2'b00, 32'h0000_0077, 3'd0, 4'd11, 4'd15, 3'd0);
    check("R8 asid before update", {32'd0, asid_out}, {32'd0, 8'h22});
    @(negedge clk);
    check("R8 asid after write", {32'd0, asid_out}, {32'd0, 8'h77});
    act_chan = 4'd5;
    @(negedge clk);
    check("R8 asid oor", {32'd0, asid_out}, 40'd0);
    act_chan = 4'd0; act_valid = 1'b0;
    @(negedge clk);
    check("R8 asid inactive", {32'd0, asid_out}, 40'd0);

    // R1 reset clears the bank
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    access(1'b0, 1'b1, 4'd1, 2'b00, 32'h0, 3'd0, 4'd11, 4'd15, 3'd0);
    check("R1 ch1 cleared", {6'd0, acc_ack, undef_trap, rd_data}, {6'd0, 2'b10, 32'h0});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule